// File: doc/BRIEF.md
# Serial EEPROM Write-Completion Poller

This block is the master side of a two-wire bus. It finds out when a serial EEPROM has finished its internal write cycle. The host pulses `start_i` right after the STOP that closed a write command. The block then sends probes one after another. Each probe is a START, then the 7-bit device address, then a direction bit of 0 (write), then a released acknowledge slot.

While the EEPROM is busy it leaves the acknowledge slot high. The block then sends STOP and starts the next probe straight away. When the EEPROM pulls the slot low, the block sends STOP and pulses `done_o`, and the host may issue its next command. If no acknowledge arrives within `MAX_PROBES` probes, the block stops polling and raises `timeout_o`.

The bus is driven as an open drain. Each `*_oe_o` output at 1 pulls its line low, and at 0 it releases the line. Bus timing comes from `CLK_DIV`: every bit cell is four quarters of `CLK_DIV` system clocks each.

Top module: `ack_poll_ctrl`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `done_o` and `timeout_o` are all 0, so both lines are released.
- R2: Each probe sends 8 bits MSB first, while SCL is high. The first 7 bits are `dev_addr_i` as sampled on the accepted `start_i`, and the 8th bit is 0. A released ninth bit follows for the acknowledge.
- R3: SDA changes only while SCL is low. The exceptions are a START (SDA falls with SCL high) and a STOP (SDA rises with SCL high). So each probe shows exactly one START and one STOP.
- R4: Every quarter lasts `CLK_DIV` cycles. Each data or acknowledge bit holds SCL high for 2 quarters. A whole probe (START, 9 bits, STOP) takes 44 quarters and shows 10 rising SCL edges.
- R5: If SDA is high when the acknowledge bit is sampled (NACK), the block sends STOP and then begins a new probe at once, unless the probe limit has been reached.
- R6: If SDA is low when the acknowledge bit is sampled (ACK) on probe k, the block sends STOP and raises `done_o` for exactly one cycle. That cycle is the one after clock edge 44·k·`CLK_DIV`, counted from the edge that accepted `start_i`. The block then returns to idle.
- R7: After `MAX_PROBES` NACKs in a row, the block raises `timeout_o` in the cycle after edge 44·`MAX_PROBES`·`CLK_DIV`. `timeout_o` then stays high until the next accepted `start_i` clears it.
- R8: `start_i` is ignored while polling is in progress. The probe count and the finishing cycle do not change.
- R9: `done_o` and `timeout_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin polling (taken only when idle) |
| dev_addr_i | input | 7 | Device address placed in every probe |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | One-cycle pulse: the device acknowledged |
| timeout_o | output | 1 | Held high when the probe limit ran out with no acknowledge |

## Verification
The bench builds the block with `CLK_DIV` = 2 and `MAX_PROBES` = 4. A probe is then 88 cycles long, so the whole sweep fits in a few thousand cycles.

A bus-level device model on the bench sweeps the busy length from 0 to 5 NACKs. That range covers an acknowledge on every possible probe, an acknowledge on the last allowed probe, and running out of probes. The sweep repeats across four address patterns, including all-zeros and all-ones. A mismatched device address checks that no acknowledge can arrive at all. A second `start_i` sent in the middle of a run checks that it has no effect on the probe count or on the finishing cycle.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } ap_state_e;
endpackage

// File: rtl/ap_tick.sv
// Quarter-bit strobe: one pulse every CLK_DIV cycles while running.
module ap_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ap_seq.sv
// Probe sequencer: START, 9 bit cells, STOP, repeated until ACK or limit.
module ap_seq
  import ap_pkg::*;
#(
  parameter int MAX_PROBES = 4,
  localparam int PW = $clog2(MAX_PROBES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [6:0]      dev_addr_i,
  input  logic            sda_i,
  input  logic            tick_i,
  output ap_state_e       st_o,
  output logic [1:0]      qtr_o,
  output logic [3:0]      bitn_o,
  output logic [6:0]      addr_o,
  output logic [PW-1:0]   probes_o,
  output logic            done_o,
  output logic            timeout_o
);
  ap_state_e     st_q;
  logic [1:0]    qtr_q;
  logic [3:0]    bitn_q;
  logic [6:0]    addr_q;
  logic [PW-1:0] probes_q;
  logic          ack_q, done_q, tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      qtr_q    <= '0;
      bitn_q   <= '0;
      addr_q   <= '0;
      probes_q <= '0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q     <= ST_START;
          qtr_q    <= '0;
          probes_q <= '0;
          ack_q    <= 1'b0;
          addr_q   <= dev_addr_i;
          tmo_q    <= 1'b0;
        end
      end else if (tick_i) begin
        qtr_q <= qtr_q + 1'b1;
        if (st_q == ST_BITS && bitn_q == 4'd8 && qtr_q == 2'd2)
          ack_q <= !sda_i;
        if (qtr_q == 2'd3) begin
          unique case (st_q)
            ST_START: begin
              st_q   <= ST_BITS;
              bitn_q <= '0;
            end
            ST_BITS: begin
              if (bitn_q == 4'd8) st_q <= ST_STOP;
              else                bitn_q <= bitn_q + 1'b1;
            end
            ST_STOP: begin
              if (ack_q) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else if (probes_q == PW'(MAX_PROBES - 1)) begin
                st_q  <= ST_IDLE;
                tmo_q <= 1'b1;
              end else begin
                probes_q <= probes_q + 1'b1;
                st_q     <= ST_START;
              end
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign st_o      = st_q;
  assign qtr_o     = qtr_q;
  assign bitn_o    = bitn_q;
  assign addr_o    = addr_q;
  assign probes_o  = probes_q;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/ap_drive.sv
// Line encoder: maps sequencer position to registered open-drain pulls.
module ap_drive
  import ap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ap_state_e  st_i,
  input  logic [1:0] qtr_i,
  input  logic [3:0] bitn_i,
  input  logic [6:0] addr_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       scl_d, sda_d, scl_q, sda_q;
  logic [7:0] frame;
  logic       bitval;

  assign frame  = {addr_i, 1'b0};
  assign bitval = frame[3'd7 - bitn_i[2:0]];

  always_comb begin
    scl_d = 1'b0;
    sda_d = sda_q;
    unique case (st_i)
      ST_IDLE:  begin scl_d = 1'b0; sda_d = 1'b0; end
      ST_START: begin scl_d = 1'b0; sda_d = (qtr_i >= 2'd2); end
      ST_BITS: begin
        scl_d = (qtr_i < 2'd2);
        if (qtr_i != 2'd0) sda_d = (bitn_i < 4'd8) && !bitval;
      end
      ST_STOP: begin
        scl_d = (qtr_i == 2'd0);
        if (qtr_i != 2'd0) sda_d = (qtr_i != 2'd3);
      end
      default: begin scl_d = 1'b0; sda_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
endmodule

// File: rtl/ack_poll_ctrl.sv
module ack_poll_ctrl
  import ap_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int MAX_PROBES = 4,
  localparam int PW = $clog2(MAX_PROBES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [6:0] dev_addr_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       timeout_o
);
  ap_state_e     st;
  logic [1:0]    qtr;
  logic [3:0]    bitn;
  logic [6:0]    addr;
  logic [PW-1:0] probes;
  logic          tick;

  ap_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(st != ST_IDLE), .tick_o(tick)
  );

  ap_seq #(.MAX_PROBES(MAX_PROBES)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .sda_i(sda_i), .tick_i(tick), .st_o(st), .qtr_o(qtr), .bitn_o(bitn),
    .addr_o(addr), .probes_o(probes), .done_o(done_o), .timeout_o(timeout_o)
  );

  ap_drive u_drv (
    .clk(clk), .rst(rst), .st_i(st), .qtr_i(qtr), .bitn_i(bitn),
    .addr_i(addr), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );
endmodule

// File: rtl/ap_checker.sv
module ap_checker
  import ap_pkg::*;
#(
  parameter int MAX_PROBES = 4,
  localparam int PW = $clog2(MAX_PROBES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic          done_o,
  input logic          timeout_o,
  input ap_state_e     st,
  input logic [PW-1:0] probes
);
  // R3: SDA moves under a high SCL only in START/STOP phases
  assert_sda_under_scl_high_R3: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe_o && $past(!scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> ($past(st) == ST_START || $past(st) == ST_STOP));

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: timeout holds until a new request
  assert_timeout_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !start_i) |=> timeout_o);

  // R7: probe index never passes the limit
  assert_probe_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (int'(probes) < MAX_PROBES));

  // R9: completion flags are exclusive
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

  // R1: lines released once idle has settled
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st) == ST_IDLE && !$past(rst)) |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind ack_poll_ctrl ap_checker #(.MAX_PROBES(MAX_PROBES)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .done_o(done_o), .timeout_o(timeout_o),
  .st(st), .probes(probes)
);

// File: tb/tb_ack_poll_ctrl.sv
module tb_ack_poll_ctrl;
  localparam int D   = 2;
  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic       scl_oe_o, sda_oe_o, done_o, timeout_o;
  logic       pull = 1'b0;
  logic       sda_i;

  assign sda_i = !(sda_oe_o || pull);

  always #4 clk = !clk;

  ack_poll_ctrl #(.CLK_DIV(D), .MAX_PROBES(MAXP)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bus-level device model
  logic [6:0] dev_addr_model = '0;
  int  busy_n = 0;
  int  starts = 0, stops = 0, rises = 0, bad_bytes = 0, bad_hi = 0;
  int  bitcnt = 10, hi_len = 0;
  logic [7:0] shreg = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [6:0] exp_addr = '0;

  always @(negedge clk) begin
    logic scl, sda;
    scl = !scl_oe_o;
    sda = !(sda_oe_o || pull);
    if (!rst) begin
      if (scl && p_scl && p_sda && !sda) begin
        starts++; bitcnt = 0; shreg = '0;
      end
      if (scl && p_scl && !p_sda && sda) stops++;
      if (scl && !p_scl) begin
        rises++; hi_len = 1;
        if (bitcnt < 8) shreg = {shreg[6:0], sda};
        bitcnt++;
      end else if (scl) hi_len++;
      if (!scl && p_scl) begin
        if (bitcnt >= 1 && bitcnt <= 9 && hi_len != 2 * D) bad_hi++;
        if (bitcnt == 8) begin
          if (shreg != {exp_addr, 1'b0}) bad_bytes++;
          if (shreg[7:1] == dev_addr_model && !shreg[0] && starts > busy_n) pull <= 1'b1;
        end else if (bitcnt == 9) pull <= 1'b0;
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  task automatic run(input logic [6:0] a, input logic [6:0] da, input int busy, input bit poke);
    int n, k;
    bit acked;
    @(posedge clk);
    starts = 0; stops = 0; rises = 0; bad_bytes = 0; bad_hi = 0;
    busy_n = busy; dev_addr_model = da; exp_addr = a;
    acked = (a == da) && (busy < MAXP);
    k = acked ? busy + 1 : MAXP;
    @(negedge clk);
    dev_addr_i = a;
    start_i = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start_i = 1'b0;
    chk(timeout_o == 1'b0, "R7 timeout cleared by start", timeout_o, 0);
    dev_addr_i = ~a;
    while (!done_o && !timeout_o && n < 2000) begin
      if (poke && n == 100) start_i = 1'b1;  // R8: request while busy
      @(posedge clk);
      n++;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (acked) begin
      chk(done_o == 1'b1 && timeout_o == 1'b0, "R6 done on ack", done_o, 1);
      chk(n == 44 * k * D + 1, poke ? "R8 finish cycle with busy request" : "R6 done cycle", n, 44 * k * D + 1);
    end else begin
      chk(timeout_o == 1'b1 && done_o == 1'b0, "R7 timeout raised", timeout_o, 1);
      chk(n == 44 * MAXP * D + 1, "R7 timeout cycle", n, 44 * MAXP * D + 1);
    end
    chk(!(done_o && timeout_o), "R9 exclusive flags", done_o + timeout_o, 1);
    @(posedge clk);
    @(negedge clk);
    if (acked) chk(done_o == 1'b0, "R6 done single cycle", done_o, 0);
    repeat (8) @(negedge clk);
    if (!acked) chk(timeout_o == 1'b1, "R7 timeout held", timeout_o, 1);
    chk(starts == k, poke ? "R8 probe count with busy request" : "R5 probe count", starts, k);
    chk(stops == k, "R3 one STOP per probe", stops, k);
    chk(bad_bytes == 0, "R2 address byte", bad_bytes, 0);
    chk(rises == 10 * k, "R4 SCL rising edges", rises, 10 * k);
    chk(bad_hi == 0, "R4 SCL high width", bad_hi, 0);
    chk(scl_oe_o == 1'b0 && sda_oe_o == 1'b0, "R1 lines released after run", scl_oe_o + sda_oe_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [6:0] addrs [4];
    addrs[0] = 7'h50; addrs[1] = 7'h00; addrs[2] = 7'h7F; addrs[3] = 7'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_oe_o == 0 && sda_oe_o == 0 && done_o == 0 && timeout_o == 0,
        "R1 reset outputs", scl_oe_o + sda_oe_o + done_o + timeout_o, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(scl_oe_o == 0 && sda_oe_o == 0, "R1 idle after reset", scl_oe_o + sda_oe_o, 0);
    for (int ai = 0; ai < 4; ai++)
      for (int b = 0; b <= MAXP + 1; b++)
        run(addrs[ai], addrs[ai], b, 1'b0);
    run(7'h50, 7'h51, 0, 1'b0);  // R7: device never answers
    run(7'h3C, 7'h3C, 2, 1'b1);  // R8: extra request ignored
    run(7'h3C, 7'h3C, 6, 1'b1);  // R8 on the timeout path
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule